// File: doc/BRIEF.md
# Transmit Frame FIFO With Command Queue

This block sits between a host and an Ethernet MAC transmit engine. The host writes 32-bit frame words into a deep data FIFO. For each frame it then pushes one command word into a separate command queue. The command holds the frame's byte length and the lane of the first valid byte in the first word, so a host buffer that is not word aligned can be copied word by word without shifting.

On the MAC side the block takes the oldest command once every word of that frame is buffered. It then delivers exactly the frame's bytes, one per handshake, with start and end markers. The host can see the occupied word count, the free word count and a three-bit status vector (full, almost full, almost empty). A flush input empties both queues and abandons any frame in progress.

Top module: `txq_tx_buffer`

## Requirements
- R1: After reset the occupied count is 0, the free count equals DEPTH (2048), the status vector is 3'b100 and out_valid is low.
- R2: A command carries the byte length in bits 15:0 and the first-byte lane (0 to 3) in bits 17:16. A frame occupies (length + lane + 3) / 4 data words, rounded down, and exactly that many words leave the data FIFO when the frame has been sent.
- R3: A frame's bytes come out in buffer order, lowest byte lane first within each word. The lanes below the offset in the first word and the unused lanes of the last word are skipped. Exactly `length` bytes are sent; out_sof marks only the first byte and out_eof only the last.
- R4: No byte of a frame is presented until its command is queued and all of its data words are buffered.
- R5: A command of length 0 sends no byte but still removes its (lane + 3) / 4 data words.
- R6: used_words reports the occupied data words and free_words reports DEPTH minus that.
- R7: Status bit 1 (almost full) is high exactly when at least DEPTH - AF_MARGIN (1664) words are occupied.
- R8: Status bit 2 (almost empty) is high exactly when at most AE_LEVEL (384) words are occupied.
- R9: Status bit 0 is high when all DEPTH words are occupied. A data write while full is ignored.
- R10: While flush is high both FIFOs are empty, host writes are ignored, out_valid is low and a pending or partly sent frame is abandoned.
- R11: While out_valid is high and out_ready is low, out_data, out_sof and out_eof hold their values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| flush | input | 1 | Clears both FIFOs while high |
| wr_data_en | input | 1 | Push one data word |
| wr_data | input | 32 | Frame data word |
| wr_cmd_en | input | 1 | Push one command |
| wr_cmd | input | 18 | Command: lane in 17:16, byte length in 15:0 |
| used_words | output | 12 | Occupied data words |
| free_words | output | 12 | Free data words |
| tx_status | output | 3 | Bit 2 almost empty, bit 1 almost full, bit 0 full |
| out_valid | output | 1 | A frame byte is presented |
| out_ready | input | 1 | MAC accepts the presented byte |
| out_data | output | 8 | Frame byte |
| out_sof | output | 1 | Presented byte is the first of its frame |
| out_eof | output | 1 | Presented byte is the last of its frame |

## Verification
The bench sends frames at every start lane and with lengths that end on each lane, including one-byte frames. A lane-selection error would show as shifted or repeated bytes, and a wrong word count would leave stale words that corrupt the next frame. A zero-length command and a command whose data is incomplete are used to catch an unpacker that emits bytes it should not, or stalls on the wrong word. The threshold flags are probed one word either side of each boundary, and a write into the full FIFO catches an off-by-one in the occupancy count. A flush is issued with a command held back, to expose a design that leaves that command behind and replays it later.

// File: rtl/txq_pkg.sv
`timescale 1ns/1ps
// Shared types for the transmit frame buffer: the command layout, the unpacker
// state and the word-count rule for a frame.
package txq_pkg;

    typedef struct packed {
        logic [1:0]  offset;   // lane of the first valid byte
        logic [15:0] length;   // frame length in bytes
    } txq_cmd_t;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_STREAM = 2'd1,
        ST_DRAIN  = 2'd2
    } txq_state_e;

    // Number of 32-bit words a frame spans: (length + offset + 3) / 4.
    function automatic logic [15:0] frame_words(input logic [15:0] len,
                                                 input logic [1:0]  off);
        logic [17:0] sum;
        sum = {2'b00, len} + {16'h0000, off} + 18'd3;
        return sum[17:2];
    endfunction

endpackage

// File: rtl/txq_fifo.sv
`timescale 1ns/1ps
// Synchronous first-word-fall-through FIFO with an occupancy count.
// Assumes DEPTH is a power of two. Writes when full and reads when empty are
// ignored. Flush empties the FIFO and blocks both ports while high.
module txq_fifo #(
    parameter int  W     = 32,
    parameter int  DEPTH = 2048,
    localparam int AW    = $clog2(DEPTH),
    localparam int CW    = AW + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          flush,
    input  logic          wr_en,
    input  logic [W-1:0]  wr_data,
    input  logic          rd_en,
    output logic [W-1:0]  rd_data,
    output logic [CW-1:0] count
);

    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] wr_ptr;
    logic [AW-1:0] rd_ptr;
    logic          do_wr;
    logic          do_rd;

    assign do_wr   = wr_en && !flush && (count != CW'(DEPTH));
    assign do_rd   = rd_en && !flush && (count != '0);
    assign rd_data = mem[rd_ptr];

    // Storage write.
    always_ff @(posedge clk) begin
        if (do_wr) begin
            mem[wr_ptr] <= wr_data;
        end
    end

    // Pointer and occupancy update.
    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (do_wr) wr_ptr <= wr_ptr + AW'(1);
            if (do_rd) rd_ptr <= rd_ptr + AW'(1);
            case ({do_wr, do_rd})
                2'b10:   count <= count + CW'(1);
                2'b01:   count <= count - CW'(1);
                default: count <= count;
            endcase
        end
    end

endmodule

// File: rtl/txq_status.sv
`timescale 1ns/1ps
// Derives the free word count and the status flags from the data occupancy.
// Status: bit 2 almost empty, bit 1 almost full, bit 0 full.
module txq_status #(
    parameter int  DEPTH     = 2048,
    parameter int  AF_MARGIN = 384,
    parameter int  AE_LEVEL  = 384,
    localparam int CW        = $clog2(DEPTH) + 1,
    localparam int AF_LEVEL  = DEPTH - AF_MARGIN
) (
    input  logic [CW-1:0] count,
    output logic [CW-1:0] free_words,
    output logic [2:0]    status
);

    // Flag and free-space decode.
    always_comb begin
        free_words = CW'(DEPTH) - count;
        status[2]  = (count <= CW'(AE_LEVEL));
        status[1]  = (count >= CW'(AF_LEVEL));
        status[0]  = (count == CW'(DEPTH));
    end

endmodule

// File: rtl/txq_unpack.sv
`timescale 1ns/1ps
// Turns queued commands and 32-bit data words into a byte stream.
// Starts a frame only when its command is at the head of the queue and all of
// its words are buffered. Bytes are taken from the lowest lane up, starting at
// the command's offset. A zero-length command drains its words silently.
module txq_unpack #(
    parameter int CW = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              flush,
    input  logic              cmd_avail,
    input  txq_pkg::txq_cmd_t cmd_head,
    output logic              cmd_pop,
    input  logic [CW-1:0]     data_count,
    input  logic [31:0]       data_head,
    output logic              data_pop,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [7:0]        out_data,
    output logic              out_sof,
    output logic              out_eof
);
    import txq_pkg::*;

    txq_state_e  state;
    logic [15:0] bytes_left;
    logic [15:0] words_left;
    logic [1:0]  lane;
    logic        first;
    logic [15:0] need_words;
    logic        launch;
    logic        fire;

    assign need_words = frame_words(cmd_head.length, cmd_head.offset);
    assign launch     = (state == ST_IDLE) && cmd_avail &&
                        (32'(data_count) >= 32'(need_words));
    assign fire       = out_valid && out_ready;
    assign cmd_pop    = launch;
    assign out_valid  = (state == ST_STREAM);
    assign out_sof    = first;
    assign out_eof    = (bytes_left == 16'd1);

    // Pop a word after its top lane or the frame's last byte, or while draining.
    always_comb begin
        data_pop = 1'b0;
        if (state == ST_STREAM && fire && (lane == 2'd3 || bytes_left == 16'd1))
            data_pop = 1'b1;
        if (state == ST_DRAIN && words_left != 16'd0)
            data_pop = 1'b1;
    end

    // Byte lane selection from the head word.
    always_comb begin
        case (lane)
            2'd0:    out_data = data_head[7:0];
            2'd1:    out_data = data_head[15:8];
            2'd2:    out_data = data_head[23:16];
            default: out_data = data_head[31:24];
        endcase
    end

    // Frame sequencing.
    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            state      <= ST_IDLE;
            bytes_left <= '0;
            words_left <= '0;
            lane       <= '0;
            first      <= 1'b0;
        end else begin
            case (state)
                ST_IDLE: begin
                    if (launch) begin
                        lane       <= cmd_head.offset;
                        bytes_left <= cmd_head.length;
                        words_left <= need_words;
                        first      <= 1'b1;
                        state      <= (cmd_head.length == 16'd0) ? ST_DRAIN : ST_STREAM;
                    end
                end
                ST_STREAM: begin
                    if (fire) begin
                        first      <= 1'b0;
                        lane       <= lane + 2'd1;
                        bytes_left <= bytes_left - 16'd1;
                        if (bytes_left == 16'd1) state <= ST_IDLE;
                    end
                end
                ST_DRAIN: begin
                    if (words_left == 16'd0) state <= ST_IDLE;
                    else                     words_left <= words_left - 16'd1;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/txq_tx_buffer.sv
`timescale 1ns/1ps
// Host-side transmit buffer: data FIFO, command queue, status decode and the
// byte unpacker. Assumes DEPTH and CMD_DEPTH are powers of two and that no
// frame spans more than DEPTH words.
module txq_tx_buffer #(
    parameter int DEPTH     = 2048,
    parameter int CMD_DEPTH = 16,
    parameter int AF_MARGIN = 384,
    parameter int AE_LEVEL  = 384
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     flush,
    input  logic                     wr_data_en,
    input  logic [31:0]              wr_data,
    input  logic                     wr_cmd_en,
    input  logic [17:0]              wr_cmd,
    output logic [$clog2(DEPTH):0]   used_words,
    output logic [$clog2(DEPTH):0]   free_words,
    output logic [2:0]               tx_status,
    output logic                     out_valid,
    input  logic                     out_ready,
    output logic [7:0]               out_data,
    output logic                     out_sof,
    output logic                     out_eof
);
    import txq_pkg::*;

    localparam int CW  = $clog2(DEPTH) + 1;
    localparam int CCW = $clog2(CMD_DEPTH) + 1;

    logic [31:0]  data_head;
    logic         data_pop;
    logic [17:0]  cmd_raw;
    logic         cmd_pop;
    logic [CCW-1:0] cmd_count;
    txq_cmd_t     cmd_head;

    assign cmd_head = txq_cmd_t'(cmd_raw);

    txq_fifo #(.W(32), .DEPTH(DEPTH)) u_data_fifo (
        .clk(clk), .rst_n(rst_n), .flush(flush),
        .wr_en(wr_data_en), .wr_data(wr_data),
        .rd_en(data_pop), .rd_data(data_head), .count(used_words)
    );

    txq_fifo #(.W(18), .DEPTH(CMD_DEPTH)) u_cmd_fifo (
        .clk(clk), .rst_n(rst_n), .flush(flush),
        .wr_en(wr_cmd_en), .wr_data(wr_cmd),
        .rd_en(cmd_pop), .rd_data(cmd_raw), .count(cmd_count)
    );

    txq_status #(.DEPTH(DEPTH), .AF_MARGIN(AF_MARGIN), .AE_LEVEL(AE_LEVEL)) u_status (
        .count(used_words), .free_words(free_words), .status(tx_status)
    );

    txq_unpack #(.CW(CW)) u_unpack (
        .clk(clk), .rst_n(rst_n), .flush(flush),
        .cmd_avail(cmd_count != '0), .cmd_head(cmd_head), .cmd_pop(cmd_pop),
        .data_count(used_words), .data_head(data_head), .data_pop(data_pop),
        .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
        .out_sof(out_sof), .out_eof(out_eof)
    );

endmodule

// File: rtl/txq_tx_buffer_chk.sv
`timescale 1ns/1ps
// Protocol and occupancy checks for the transmit frame buffer, bound to the top.
module txq_tx_buffer_chk #(
    parameter int  DEPTH     = 2048,
    parameter int  AF_MARGIN = 384,
    parameter int  AE_LEVEL  = 384,
    localparam int CW        = $clog2(DEPTH) + 1,
    localparam int AF_LEVEL  = DEPTH - AF_MARGIN
) (
    input logic          clk,
    input logic          rst_n,
    input logic          flush,
    input logic          out_valid,
    input logic          out_ready,
    input logic [7:0]    out_data,
    input logic          out_sof,
    input logic          out_eof,
    input logic [CW-1:0] used_words,
    input logic [2:0]    tx_status
);

    assert_hold_stable_R11: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_ready && !flush |=>
        out_valid && $stable(out_data) && $stable(out_sof) && $stable(out_eof));

    assert_frame_start_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(out_valid) |-> out_sof);

    assert_frame_end_R3: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && out_ready && out_eof |=> !out_valid);

    assert_no_overflow_R9: assert property (@(posedge clk) disable iff (!rst_n)
        used_words <= CW'(DEPTH));

    assert_count_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !flush |=> (used_words == $past(used_words)) ||
                   (used_words == $past(used_words) + CW'(1)) ||
                   (used_words == $past(used_words) - CW'(1)));

    assert_flush_clears_R10: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (used_words == '0) && !out_valid);

    assert_af_rise_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tx_status[1]) |-> used_words == CW'(AF_LEVEL));

    assert_ae_rise_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tx_status[2]) && !$past(flush) |-> used_words == CW'(AE_LEVEL));

endmodule

bind txq_tx_buffer txq_tx_buffer_chk #(
    .DEPTH(DEPTH), .AF_MARGIN(AF_MARGIN), .AE_LEVEL(AE_LEVEL)
) u_chk (
    .clk(clk), .rst_n(rst_n), .flush(flush),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
    .out_sof(out_sof), .out_eof(out_eof),
    .used_words(used_words), .tx_status(tx_status)
);

// File: tb/txq_tx_buffer_tb.sv
`timescale 1ns/1ps
module txq_tx_buffer_tb;

    localparam int DEPTH = 2048;
    localparam int CW    = $clog2(DEPTH) + 1;
    localparam int NVEC  = 10;
    // {exp_words[35:32], stall[24], offset[17:16], length[15:0]}
    localparam logic [35:0] VEC [NVEC] = '{
        {4'd1, 7'd0, 1'b0, 6'd0, 2'd0, 16'd1},
        {4'd1, 7'd0, 1'b0, 6'd0, 2'd3, 16'd1},
        {4'd1, 7'd0, 1'b0, 6'd0, 2'd0, 16'd4},
        {4'd2, 7'd0, 1'b1, 6'd0, 2'd3, 16'd5},
        {4'd1, 7'd0, 1'b0, 6'd0, 2'd1, 16'd3},
        {4'd3, 7'd0, 1'b1, 6'd0, 2'd2, 16'd8},
        {4'd1, 7'd0, 1'b0, 6'd0, 2'd2, 16'd2},
        {4'd2, 7'd0, 1'b0, 6'd0, 2'd0, 16'd7},
        {4'd1, 7'd0, 1'b0, 6'd0, 2'd2, 16'd0},
        {4'd3, 7'd0, 1'b1, 6'd0, 2'd3, 16'd6}
    };

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          flush = 1'b0;
    logic          wr_data_en = 1'b0;
    logic [31:0]   wr_data = '0;
    logic          wr_cmd_en = 1'b0;
    logic [17:0]   wr_cmd = '0;
    logic [CW-1:0] used_words;
    logic [CW-1:0] free_words;
    logic [2:0]    tx_status;
    logic          out_valid;
    logic          out_ready = 1'b0;
    logic [7:0]    out_data;
    logic          out_sof;
    logic          out_eof;

    int   checks = 0;
    int   errors = 0;
    bit   done = 1'b0;
    bit   stall_mode = 1'b0;
    int   tick = 0;
    int   rx_n = 0;
    logic [7:0] rx_byte [0:1023];
    logic       rx_sof  [0:1023];
    logic       rx_eof  [0:1023];

    always #2 clk = ~clk;

    txq_tx_buffer u_dut (
        .clk(clk), .rst_n(rst_n), .flush(flush),
        .wr_data_en(wr_data_en), .wr_data(wr_data),
        .wr_cmd_en(wr_cmd_en), .wr_cmd(wr_cmd),
        .used_words(used_words), .free_words(free_words), .tx_status(tx_status),
        .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
        .out_sof(out_sof), .out_eof(out_eof)
    );

    // Sink: choose ready for the next edge, then log the byte that edge takes.
    always @(negedge clk) begin
        tick++;
        out_ready = stall_mode ? ((tick % 3) != 0) : 1'b1;
        if (out_valid && out_ready) begin
            rx_byte[rx_n] = out_data;
            rx_sof[rx_n]  = out_sof;
            rx_eof[rx_n]  = out_eof;
            rx_n++;
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic summary();
        if (!done) begin
            done = 1'b1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    function automatic logic [31:0] mkword(input logic [7:0] seed, input int i);
        logic [7:0] b;
        b = seed + 8'(4 * i);
        return {b + 8'd3, b + 8'd2, b + 8'd1, b};
    endfunction

    task automatic push_word(input logic [31:0] w);
        wr_data_en = 1'b1;
        wr_data    = w;
        @(negedge clk);
        wr_data_en = 1'b0;
    endtask

    task automatic push_cmd(input int len, input int off);
        wr_cmd_en = 1'b1;
        wr_cmd    = {2'(off), 16'(len)};
        @(negedge clk);
        wr_cmd_en = 1'b0;
    endtask

    // Compare received bytes with the buffer image seed+off+k (R3).
    task automatic check_frame(input int base, input int len, input int off,
                               input logic [7:0] seed, input string req);
        int bad;
        bad = -1;
        #1;
        chk(rx_n - base == len, req, rx_n - base, len);
        for (int k = 0; k < len; k++) begin
            if (bad < 0 && (rx_byte[base+k] != seed + 8'(off + k) ||
                            rx_sof[base+k] != (k == 0) ||
                            rx_eof[base+k] != (k == len - 1)))
                bad = k;
        end
        chk(bad < 0, "R3 byte order and markers", bad, -1);
    endtask

    task automatic wait_bytes(input int base, input int len);
        int waited;
        waited = 0;
        while ((rx_n - base) < len && waited < 500) begin
            @(negedge clk);
            waited++;
        end
        repeat (8) @(negedge clk);
    endtask

    task automatic run_frame(input int len, input int off, input int exp_w,
                             input bit stall, input logic [7:0] seed);
        int base;
        int nw;
        stall_mode = stall;
        base = rx_n;
        nw = (len + off + 3) / 4;
        for (int i = 0; i < nw; i++) push_word(mkword(seed, i));
        chk(used_words == CW'(exp_w), "R2 words buffered", int'(used_words), exp_w);
        push_cmd(len, off);
        wait_bytes(base, len);
        check_frame(base, len, off, seed, stall ? "R11 byte count under stall" :
                                          (len == 0 ? "R5 no bytes" : "R3 byte count"));
        chk(used_words == '0, len == 0 ? "R5 words drained" : "R2 words consumed",
            int'(used_words), 0);
    endtask

    initial begin
        #(4 * 190000);
        checks++;
        errors++;
        $display("FAIL watchdog expired");
        summary();
    end

    initial begin
        int base;
        bit seen;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        chk(used_words == '0, "R1 used after reset", int'(used_words), 0);
        chk(free_words == CW'(DEPTH), "R1 free after reset", int'(free_words), DEPTH);
        chk(tx_status == 3'b100, "R1 status after reset", int'(tx_status), 4);
        chk(!out_valid, "R1 out_valid after reset", int'(out_valid), 0);

        // Table of frames: length, offset, expected words, stall.
        for (int v = 0; v < NVEC; v++) begin
            run_frame(int'(VEC[v][15:0]), int'(VEC[v][17:16]), int'(VEC[v][35:32]),
                      VEC[v][24], 8'(16 * v + 1));
        end

        // R4: command present but data incomplete must not start.
        stall_mode = 1'b0;
        base = rx_n;
        push_word(mkword(8'hA0, 0));
        push_cmd(8, 0);
        seen = 1'b0;
        repeat (20) begin
            @(negedge clk);
            if (out_valid) seen = 1'b1;
        end
        chk(!seen, "R4 frame held until words present", int'(seen), 0);
        push_word(mkword(8'hA0, 1));
        wait_bytes(base, 8);
        check_frame(base, 8, 0, 8'hA0, "R4 held frame count");

        // R10: flush with a held command, writes attempted during flush.
        base = rx_n;
        push_word(mkword(8'hC0, 0));
        push_cmd(12, 0);
        repeat (4) @(negedge clk);
        flush = 1'b1;
        wr_data_en = 1'b1;
        wr_data = 32'h1234_5678;
        wr_cmd_en = 1'b1;
        wr_cmd = {2'd0, 16'd1};
        @(negedge clk);
        chk(used_words == '0, "R10 empty during flush", int'(used_words), 0);
        chk(!out_valid, "R10 idle during flush", int'(out_valid), 0);
        repeat (2) @(negedge clk);
        flush = 1'b0;
        wr_data_en = 1'b0;
        wr_cmd_en = 1'b0;
        repeat (10) @(negedge clk);
        #1;
        chk(used_words == '0, "R10 writes during flush ignored", int'(used_words), 0);
        chk(rx_n == base, "R10 stale command dropped", rx_n - base, 0);
        run_frame(3, 1, 1, 1'b0, 8'h50);

        // R6 R7 R8 R9 thresholds, filling with no command queued.
        for (int i = 0; i < 384; i++) push_word(32'(i));
        chk(used_words == 12'd384, "R6 used count", int'(used_words), 384);
        chk(free_words == 12'd1664, "R6 free count", int'(free_words), 1664);
        chk(tx_status[2] == 1'b1, "R8 almost empty at 384", int'(tx_status[2]), 1);
        push_word(32'h0);
        chk(tx_status[2] == 1'b0, "R8 almost empty clear at 385", int'(tx_status[2]), 0);
        for (int i = 385; i < 1663; i++) push_word(32'(i));
        chk(tx_status[1] == 1'b0, "R7 almost full clear at 1663", int'(tx_status[1]), 0);
        push_word(32'h0);
        chk(tx_status[1] == 1'b1, "R7 almost full at 1664", int'(tx_status[1]), 1);
        chk(tx_status[0] == 1'b0, "R9 not full at 1664", int'(tx_status[0]), 0);
        for (int i = 1664; i < DEPTH; i++) push_word(32'(i));
        chk(tx_status[0] == 1'b1, "R9 full at 2048", int'(tx_status[0]), 1);
        chk(free_words == '0, "R6 free zero when full", int'(free_words), 0);
        push_word(32'hDEAD_BEEF);
        chk(used_words == CW'(DEPTH), "R9 write when full ignored", int'(used_words), DEPTH);
        flush = 1'b1;
        @(negedge clk);
        flush = 1'b0;
        @(negedge clk);
        chk(tx_status == 3'b100, "R10 status after flush", int'(tx_status), 4);

        summary();
    end

endmodule